// File: doc/BRIEF.md
# Predicate Mask Lookup Unit

This unit turns a small set of predication configuration slots into the per-element enable mask that a parallel issue loop needs for one operation. Software programs up to sixteen slots. Each slot names an operation type (integer or floating point) and a destination register number, and says which integer register holds the mask for that destination. A slot can also ask for the mask to be inverted, and it carries a zeroing hint that travels with the mask.

After any slot write, the unit rebuilds two 32-entry lookup tables in hardware, one per operation type. It first wipes both tables, then walks the slots in order. While this runs, `lk_ready` is low.

The issue stage presents a type bit and a destination register number. In the same cycle the unit drives the address of the mask register onto an external synchronous-read port of the integer register file. One cycle later it returns the mask, the zeroing flag and a valid strobe. A destination with no enabled table entry returns an all-ones mask, so every element is active.

Top module: `predmask_lookup`

## Requirements
- R1: After reset `lk_ready` is high, `mk_valid` is low, and every lookup returns an all-ones mask with `mk_zero` low until a slot is programmed.
- R2: `mk_valid` is high in the cycle that follows exactly one cycle after a request taken while `lk_ready` is high, and low in every other cycle. Requests on consecutive cycles give valid results on consecutive cycles.
- R3: For an enabled table entry, `rf_raddr` in the request cycle is {bank bit, 5-bit mask register index}, so bank 1 addresses 32 + index. `mk_mask` equals the data returned from that address.
- R4: When the entry's invert flag is set, `mk_mask` is the bitwise complement of the register data.
- R5: `mk_zero` reports the zeroing flag of the matched entry and is low for a destination that has no entry.
- R6: Integer and floating-point entries live in separate tables. A slot keyed on register k of one type has no effect on a lookup of register k of the other type, nor on other register numbers.
- R7: A slot write drops `lk_ready` on the next cycle and holds it low for NUM_SLOTS+1 cycles (17 at default): one clear cycle, then one cycle per slot. A write during a rebuild restarts the count.
- R8: A request made while `lk_ready` is low is dropped and produces no `mk_valid`.
- R9: A rebuild starts from empty tables, so clearing a slot's in-use bit makes its destination unpredicated again.
- R10: When two in-use slots carry the same type and key, the slot with the higher slot number decides the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Slot write strobe |
| cfg_slot | input | SLOT_AW | Slot number written |
| cfg_used | input | 1 | Slot in use |
| cfg_is_fp | input | 1 | Slot type: 1 floating point, 0 integer |
| cfg_key | input | 5 | Destination register the slot applies to |
| cfg_src | input | 5 | Integer register that holds the mask |
| cfg_inv | input | 1 | Invert the mask |
| cfg_zero | input | 1 | Zeroing hint for masked-off elements |
| cfg_bank | input | 1 | Register bank bit (bit 5 of the mask address) |
| lk_req | input | 1 | Lookup request |
| lk_is_fp | input | 1 | Operation type of the lookup |
| lk_reg | input | 5 | Destination register of the lookup |
| lk_ready | output | 1 | Tables are stable; requests are accepted |
| rf_raddr | output | 6 | Register file read address (data returned next cycle) |
| rf_rdata | input | XLEN | Register file read data |
| mk_mask | output | XLEN | Effective predicate mask |
| mk_zero | output | 1 | Zeroing flag of the matched entry |
| mk_valid | output | 1 | Mask and flag are valid |

## Verification
A wrong table entry shows at the ports on the very next lookup of that destination. It appears as a mask from the wrong register, a complemented or uncomplemented mask, an all-ones mask where one was expected (or the reverse), or a wrong zeroing flag, all one cycle after the request. A sequencer fault is visible through the length of the `lk_ready` low window after a write, and through a lookup of a slot near either end of the walk. An entry left over from a previous build shows up as soon as a removed or superseded slot is looked up. A lost or spurious result shows in `mk_valid` in the cycle right after the request.

// File: rtl/predmask_pkg.sv
`timescale 1ns/1ps
package predmask_pkg;
   localparam int PM_REG_AW  = 5;
   localparam int PM_RIDX_W  = PM_REG_AW + 1;
   localparam int PM_NREGS   = 1 << PM_REG_AW;

   typedef struct packed {
      logic                 used;
      logic                 is_fp;
      logic [PM_REG_AW-1:0] key;
      logic [PM_REG_AW-1:0] src;
      logic                 inv;
      logic                 zero;
      logic                 bank;
   } pm_slot_t;

   typedef struct packed {
      logic                 en;
      logic                 inv;
      logic                 zero;
      logic [PM_RIDX_W-1:0] ridx;
   } pm_ent_t;

   typedef enum logic [1:0] {
      PM_IDLE  = 2'd0,
      PM_CLEAR = 2'd1,
      PM_SCAN  = 2'd2
   } pm_state_e;
endpackage

// File: rtl/pm_slot_store.sv
`timescale 1ns/1ps
module pm_slot_store
   import predmask_pkg::*;
#(
   parameter int NUM_SLOTS = 16,
   localparam int SLOT_AW  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [SLOT_AW-1:0] wr_idx,
   input  pm_slot_t           wr_data,
   input  logic [SLOT_AW-1:0] rd_idx,
   output pm_slot_t           rd_data
);
   pm_slot_t slots [NUM_SLOTS];

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            slots[s] <= '0;
         else if (wr_en && (wr_idx == SLOT_AW'(s)))
            slots[s] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int s = 0; s < NUM_SLOTS; s++)
         if (rd_idx == SLOT_AW'(s))
            rd_data = slots[s];
   end
endmodule

// File: rtl/pm_table_build.sv
`timescale 1ns/1ps
module pm_table_build
   import predmask_pkg::*;
#(
   parameter int NUM_SLOTS = 16,
   localparam int SLOT_AW  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rebuild,
   output logic [SLOT_AW-1:0]   scan_idx,
   input  pm_slot_t             scan_slot,
   output logic                 ready,
   input  logic                 q_is_fp,
   input  logic [PM_REG_AW-1:0] q_reg,
   output pm_ent_t              q_ent
);
   localparam logic [SLOT_AW-1:0] LAST = SLOT_AW'(NUM_SLOTS - 1);

   pm_state_e          state;
   logic [SLOT_AW-1:0] cnt;
   pm_ent_t            tab [2][PM_NREGS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= PM_IDLE;
         cnt   <= '0;
      end else if (rebuild) begin
         state <= PM_CLEAR;
         cnt   <= '0;
      end else begin
         case (state)
            PM_CLEAR: state <= PM_SCAN;
            PM_SCAN: begin
               if (cnt == LAST) state <= PM_IDLE;
               else             cnt   <= cnt + 1'b1;
            end
            default: state <= PM_IDLE;
         endcase
      end
   end

   for (genvar t = 0; t < 2; t++) begin : g_type
      for (genvar r = 0; r < PM_NREGS; r++) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n || (state == PM_CLEAR && !rebuild)) begin
               tab[t][r] <= '0;
            end else if (state == PM_SCAN && !rebuild && scan_slot.used &&
                         (scan_slot.is_fp == 1'(t)) &&
                         (scan_slot.key == PM_REG_AW'(r))) begin
               tab[t][r].en   <= 1'b1;
               tab[t][r].inv  <= scan_slot.inv;
               tab[t][r].zero <= scan_slot.zero;
               tab[t][r].ridx <= {scan_slot.bank, scan_slot.src};
            end
         end
      end
   end

   assign scan_idx = cnt;
   assign ready    = (state == PM_IDLE);
   assign q_ent    = tab[q_is_fp][q_reg];
endmodule

// File: rtl/pm_mask_stage.sv
`timescale 1ns/1ps
module pm_mask_stage
   import predmask_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            accept,
   input  pm_ent_t         ent,
   input  logic [XLEN-1:0] rf_rdata,
   output logic [XLEN-1:0] mask,
   output logic            zero,
   output logic            valid
);
   logic en_q, inv_q, zero_q, valid_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         inv_q   <= 1'b0;
         zero_q  <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= accept;
         if (accept) begin
            en_q   <= ent.en;
            inv_q  <= ent.inv;
            zero_q <= ent.en & ent.zero;
         end
      end
   end

   always_comb begin
      if (!en_q)     mask = '1;
      else if (inv_q) mask = ~rf_rdata;
      else            mask = rf_rdata;
   end

   assign zero  = zero_q;
   assign valid = valid_q;
endmodule

// File: rtl/predmask_lookup.sv
`timescale 1ns/1ps
module predmask_lookup
   import predmask_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int NUM_SLOTS = 16,
   localparam int SLOT_AW  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [SLOT_AW-1:0]   cfg_slot,
   input  logic                 cfg_used,
   input  logic                 cfg_is_fp,
   input  logic [PM_REG_AW-1:0] cfg_key,
   input  logic [PM_REG_AW-1:0] cfg_src,
   input  logic                 cfg_inv,
   input  logic                 cfg_zero,
   input  logic                 cfg_bank,
   input  logic                 lk_req,
   input  logic                 lk_is_fp,
   input  logic [PM_REG_AW-1:0] lk_reg,
   output logic                 lk_ready,
   output logic [PM_RIDX_W-1:0] rf_raddr,
   input  logic [XLEN-1:0]      rf_rdata,
   output logic [XLEN-1:0]      mk_mask,
   output logic                 mk_zero,
   output logic                 mk_valid
);
   if (XLEN < 1) begin : g_bad_xlen
      $error("predmask_lookup: XLEN must be positive");
   end
   if (NUM_SLOTS < 1 || NUM_SLOTS > 64) begin : g_bad_slots
      $error("predmask_lookup: NUM_SLOTS must be 1..64");
   end

   pm_slot_t           wr_slot, scan_slot;
   logic [SLOT_AW-1:0] scan_idx;
   pm_ent_t            q_ent;
   logic               accept;

   assign wr_slot = '{used: cfg_used, is_fp: cfg_is_fp, key: cfg_key,
                      src: cfg_src, inv: cfg_inv, zero: cfg_zero,
                      bank: cfg_bank};

   pm_slot_store #(.NUM_SLOTS(NUM_SLOTS)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_idx  (cfg_slot),
      .wr_data (wr_slot),
      .rd_idx  (scan_idx),
      .rd_data (scan_slot)
   );

   pm_table_build #(.NUM_SLOTS(NUM_SLOTS)) u_build (
      .clk       (clk),
      .rst_n     (rst_n),
      .rebuild   (cfg_we),
      .scan_idx  (scan_idx),
      .scan_slot (scan_slot),
      .ready     (lk_ready),
      .q_is_fp   (lk_is_fp),
      .q_reg     (lk_reg),
      .q_ent     (q_ent)
   );

   assign accept   = lk_req & lk_ready;
   assign rf_raddr = q_ent.ridx;

   pm_mask_stage #(.XLEN(XLEN)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .ent      (q_ent),
      .rf_rdata (rf_rdata),
      .mask     (mk_mask),
      .zero     (mk_zero),
      .valid    (mk_valid)
   );
endmodule

// File: rtl/predmask_lookup_chk.sv
`timescale 1ns/1ps
module predmask_lookup_chk #(
   parameter int NUM_SLOTS = 16
) (
   input logic clk,
   input logic rst_n,
   input logic cfg_we,
   input logic lk_req,
   input logic lk_ready,
   input logic mk_valid
);
   localparam int CW = $clog2(NUM_SLOTS + 3) + 1;
   logic [CW-1:0] low_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          low_cnt <= '0;
      else if (cfg_we)     low_cnt <= '0;
      else if (!lk_ready)  low_cnt <= low_cnt + 1'b1;
   end

   // R2
   valid_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && lk_ready) |=> mk_valid);

   // R2
   no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(lk_req && lk_ready)) |=> !mk_valid);

   // R7
   ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> !lk_ready);

   // R7
   rebuild_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lk_ready) |-> (low_cnt == CW'(NUM_SLOTS + 1)));

   // R8
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && !lk_ready) |=> !mk_valid);
endmodule

bind predmask_lookup predmask_lookup_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_we   (cfg_we),
   .lk_req   (lk_req),
   .lk_ready (lk_ready),
   .mk_valid (mk_valid)
);

// File: tb/predmask_lookup_bench.sv
`timescale 1ns/1ps
module predmask_lookup_bench;
   localparam int XLEN = 32;
   localparam int NS   = 16;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we, cfg_used, cfg_is_fp, cfg_inv, cfg_zero, cfg_bank;
   logic [3:0]  cfg_slot;
   logic [4:0]  cfg_key, cfg_src;
   logic        lk_req, lk_is_fp, lk_ready;
   logic [4:0]  lk_reg;
   logic [5:0]  rf_raddr;
   logic [31:0] rf_rdata, mk_mask;
   logic        mk_zero, mk_valid;
   logic [31:0] rf_mem [64];

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   predmask_lookup #(.XLEN(XLEN), .NUM_SLOTS(NS)) u_predmask_lookup (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
      .cfg_used(cfg_used), .cfg_is_fp(cfg_is_fp), .cfg_key(cfg_key),
      .cfg_src(cfg_src), .cfg_inv(cfg_inv), .cfg_zero(cfg_zero),
      .cfg_bank(cfg_bank), .lk_req(lk_req), .lk_is_fp(lk_is_fp),
      .lk_reg(lk_reg), .lk_ready(lk_ready), .rf_raddr(rf_raddr),
      .rf_rdata(rf_rdata), .mk_mask(mk_mask), .mk_zero(mk_zero),
      .mk_valid(mk_valid)
   );

   always_ff @(posedge clk) rf_rdata <= rf_mem[rf_raddr];

   function automatic logic [31:0] rfv(int a);
      return 32'h1357_9BDF ^ (32'(a) * 32'h0101_0307);
   endfunction

   task automatic chk(bit ok, string req, string what,
                      logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic write_slot(int idx, bit used, bit fp, int key, int src,
                             bit inv, bit zero, bit bank);
      @(negedge clk);
      cfg_we = 1; cfg_slot = 4'(idx); cfg_used = used; cfg_is_fp = fp;
      cfg_key = 5'(key); cfg_src = 5'(src); cfg_inv = inv;
      cfg_zero = zero; cfg_bank = bank;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic wait_ready(bit check_len, string req);
      int n = 0;
      while (!lk_ready && n < 100) begin
         n++;
         @(negedge clk);
      end
      if (check_len) chk(n == NS + 1, req, "ready low cycles", n, NS + 1);
   endtask

   task automatic lookup(bit fp, int r, logic [31:0] exp_m, bit exp_z,
                         bit chk_addr, int exp_addr, string req);
      @(negedge clk);
      lk_req = 1; lk_is_fp = fp; lk_reg = 5'(r);
      #1;
      if (chk_addr) chk(rf_raddr == 6'(exp_addr), req, "rf_raddr",
                        32'(rf_raddr), exp_addr);
      @(negedge clk);
      lk_req = 0;
      chk(mk_valid == 1'b1, req, "valid", 32'(mk_valid), 1);
      chk(mk_mask == exp_m, req, "mask", mk_mask, exp_m);
      chk(mk_zero == exp_z, req, "zero", 32'(mk_zero), 32'(exp_z));
   endtask

   task automatic t_reset;
      chk(lk_ready == 1'b1, "R1", "ready after reset", 32'(lk_ready), 1);
      chk(mk_valid == 1'b0, "R1", "valid after reset", 32'(mk_valid), 0);
      lookup(0, 3, '1, 0, 0, 0, "R1");
      lookup(1, 31, '1, 0, 0, 0, "R5");
   endtask

   task automatic t_basic;
      write_slot(0, 1, 0, 4, 7, 0, 1, 0);
      chk(lk_ready == 1'b0, "R7", "ready after write", 32'(lk_ready), 0);
      wait_ready(1, "R7");
      lookup(0, 4, rfv(7), 1, 1, 7, "R3");
      lookup(1, 4, '1, 0, 0, 0, "R6");
      lookup(0, 5, '1, 0, 0, 0, "R6");
   endtask

   task automatic t_invert_fp;
      write_slot(1, 1, 1, 4, 9, 1, 0, 0);
      wait_ready(1, "R7");
      lookup(1, 4, ~rfv(9), 0, 1, 9, "R4");
      lookup(0, 4, rfv(7), 1, 0, 0, "R6");
   endtask

   task automatic t_bank;
      write_slot(15, 1, 0, 10, 3, 0, 0, 1);
      wait_ready(1, "R7");
      lookup(0, 10, rfv(35), 0, 1, 35, "R3");
   endtask

   task automatic t_duplicate;
      write_slot(5, 1, 0, 4, 12, 0, 0, 0);
      wait_ready(0, "R10");
      lookup(0, 4, rfv(12), 0, 1, 12, "R10");
      write_slot(5, 0, 0, 4, 12, 0, 0, 0);
      wait_ready(0, "R9");
      lookup(0, 4, rfv(7), 1, 1, 7, "R9");
   endtask

   task automatic t_remove;
      write_slot(0, 0, 0, 4, 7, 0, 1, 0);
      wait_ready(0, "R9");
      lookup(0, 4, '1, 0, 0, 0, "R9");
      lookup(1, 4, ~rfv(9), 0, 0, 0, "R9");
   endtask

   task automatic t_back_to_back;
      @(negedge clk);
      lk_req = 1; lk_is_fp = 0; lk_reg = 5'd10;
      @(negedge clk);
      chk(mk_valid == 1'b1, "R2", "valid first", 32'(mk_valid), 1);
      chk(mk_mask == rfv(35), "R2", "mask first", mk_mask, rfv(35));
      lk_is_fp = 1; lk_reg = 5'd4;
      @(negedge clk);
      chk(mk_valid == 1'b1, "R2", "valid second", 32'(mk_valid), 1);
      chk(mk_mask == ~rfv(9), "R2", "mask second", mk_mask, ~rfv(9));
      lk_req = 0;
      @(negedge clk);
      chk(mk_valid == 1'b0, "R2", "valid after idle", 32'(mk_valid), 0);
   endtask

   task automatic t_busy;
      write_slot(7, 1, 1, 20, 21, 0, 1, 0);
      lk_req = 1; lk_is_fp = 1; lk_reg = 5'd20;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk(mk_valid == 1'b0, "R8", "valid while busy", 32'(mk_valid), 0);
      end
      lk_req = 0;
      wait_ready(0, "R8");
      @(negedge clk);
      chk(mk_valid == 1'b0, "R8", "no late valid", 32'(mk_valid), 0);
      lookup(1, 20, rfv(21), 1, 1, 21, "R5");
   endtask

   task automatic t_restart;
      write_slot(9, 0, 0, 1, 1, 0, 0, 0);
      write_slot(10, 0, 0, 2, 2, 0, 0, 0);
      wait_ready(1, "R7");
   endtask

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int a = 0; a < 64; a++) rf_mem[a] = rfv(a);
      rst_n = 0; cfg_we = 0; cfg_slot = 0; cfg_used = 0; cfg_is_fp = 0;
      cfg_key = 0; cfg_src = 0; cfg_inv = 0; cfg_zero = 0; cfg_bank = 0;
      lk_req = 0; lk_is_fp = 0; lk_reg = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset;
      t_basic;
      t_invert_fp;
      t_bank;
      t_duplicate;
      t_remove;
      t_back_to_back;
      t_busy;
      t_restart;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule